// File: doc/BRIEF.md
# Cache Coherence Directory Controller

This block keeps the coherence record for a small set of cached lines shared by a few cores. For every line it holds three bit vectors with one bit per core: a valid bit, a dirty bit and a shared bit. Together the three bits give each core's copy one of five states: modified, owned, exclusive, shared or invalid. A core's second-level cache sends the controller one of four requests for a line: claim ownership (invalidate), give the line up (writeback), read to load, or read to store. The controller works out the next state of every core's copy of that line. It sends snoop commands to the other cores, waits until every snooped core has acknowledged, and fetches the line from main memory when no other core can supply it. It then replies to the requester and writes the new states into the directory.

The controller handles one request at a time. While a request is in progress it refuses new ones, so the directory entries can never be updated by two requests at once. A probe port reads any line's three vectors combinationally, so the surrounding logic and the bench can see the recorded state.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset every line reads back all-zero valid, dirty and shared vectors (all cores Invalid), `req_ready` is 1, and `snp_valid`, `mem_req` and `rsp_valid` are 0. The per-core state code is {valid,dirty,shared}: 0xx Invalid, 100 Exclusive, 101 Shared, 110 Modified, 111 Owned.
- R2: Invalidate request (`req_op` 0): every other core holding a valid copy receives snoop command 1 (invalidate) and becomes Invalid; the requester becomes Modified; memory is not accessed.
- R3: Writeback request (`req_op` 1): every other valid copy receives command 1 and becomes Invalid; the requester becomes Invalid; memory is not accessed.
- R4: Read-for-load (`req_op` 2) with a home core present: the home is the lowest-numbered core other than the requester in Exclusive, Modified or Owned. It receives command 2 (copy back and keep) and becomes Owned. All other cores keep their state and get no command, the requester becomes Shared, and memory is not accessed.
- R5: Read-for-store (`req_op` 3): the home core, if any, receives command 3 (copy back and drop). Every other valid copy receives command 1. All of these become Invalid, and the requester becomes Modified.
- R6: A read request that finds no home core fetches the line from main memory (`mem_req` with `mem_line` equal to the request line), even when other cores hold Shared copies. The reply then carries `rsp_mem`=1. It carries 0 when no fetch took place.
- R7: Snoop commands are presented for exactly one cycle with `snp_valid`. Core i's command sits at `snp_cmd[2i+1:2i]`. `rsp_valid` is raised only after every snooped core has pulsed its `snp_ack` bit, and acks from cores that were not snooped are ignored.
- R8: `mem_req` is raised only after all snoop acks have arrived and stays high until `mem_ack`.
- R9: `req_ready` is low from the cycle after acceptance until the reply has been given. A request presented while busy is ignored and changes no directory entry. `req_ready` returns to 1 in the cycle after `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle if valid |
| req_core | input | CW | Requesting core |
| req_op | input | 2 | 0 invalidate, 1 writeback, 2 read-for-load, 3 read-for-store |
| req_line | input | LW | Directory line index |
| snp_valid | output | 1 | Snoop commands valid (one cycle) |
| snp_cmd | output | 2*NCORE | Per-core command: 0 none, 1 invalidate, 2 copy back and keep, 3 copy back and drop |
| snp_ack | input | NCORE | Per-core acknowledge pulses |
| mem_req | output | 1 | Memory fetch request |
| mem_line | output | LW | Line to fetch |
| mem_ack | input | 1 | Memory fetch complete |
| rsp_valid | output | 1 | Reply to requester (one cycle) |
| rsp_core | output | CW | Core being answered |
| rsp_mem | output | 1 | Data came from main memory |
| look_line | input | LW | Probe line index |
| look_v | output | NCORE | Probe: valid vector |
| look_d | output | NCORE | Probe: dirty vector |
| look_s | output | NCORE | Probe: shared vector |

## Verification
The bench drives a line from miss to modified, then to owned, and then steals it with a store. Along the way it targets the cases a wrong design would get visibly wrong:
- A read that finds only Shared copies must still go to memory. A controller that treats a sharer as the source would skip `mem_req` and reply with stale-source data.
- Acks are staggered and spurious acks are mixed in. A design that counts any ack, or compares the ack set one cycle early, replies before a snooped core has finished.
- Home priority is tested with an owner alongside sharers, where only the owner may receive a copy-back command.
- A rogue request is injected mid-transaction. An unserialised design would let it corrupt a line that nobody legitimately touched.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    OP_INV  = 2'd0,
    OP_WB   = 2'd1,
    OP_RDLD = 2'd2,
    OP_RDST = 2'd3
  } coh_op_e;

  typedef enum logic [1:0] {
    SN_NONE  = 2'd0,
    SN_INV   = 2'd1,
    SN_SHARE = 2'd2,
    SN_FLUSH = 2'd3
  } snp_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_MEM   = 3'd3,
    ST_REPLY = 3'd4
  } ctl_state_e;
endpackage

// File: rtl/coh_dir_array.sv
module coh_dir_array #(
  parameter int NCORE = 4,
  parameter int NLINE = 8,
  localparam int LW = $clog2(NLINE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LW-1:0]    rd_line,
  output logic [NCORE-1:0] rd_v,
  output logic [NCORE-1:0] rd_d,
  output logic [NCORE-1:0] rd_s,
  input  logic [LW-1:0]    pr_line,
  output logic [NCORE-1:0] pr_v,
  output logic [NCORE-1:0] pr_d,
  output logic [NCORE-1:0] pr_s,
  input  logic             we,
  input  logic [LW-1:0]    wr_line,
  input  logic [NCORE-1:0] wr_v,
  input  logic [NCORE-1:0] wr_d,
  input  logic [NCORE-1:0] wr_s
);
  logic [NCORE-1:0] v_q [NLINE];
  logic [NCORE-1:0] d_q [NLINE];
  logic [NCORE-1:0] s_q [NLINE];

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    logic line_en;
    assign line_en = we && (wr_line == LW'(l));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[l] <= '0;
        d_q[l] <= '0;
        s_q[l] <= '0;
      end else if (line_en) begin
        v_q[l] <= wr_v;
        d_q[l] <= wr_d;
        s_q[l] <= wr_s;
      end
    end
  end

  assign rd_v = v_q[rd_line];
  assign rd_d = d_q[rd_line];
  assign rd_s = s_q[rd_line];
  assign pr_v = v_q[pr_line];
  assign pr_d = d_q[pr_line];
  assign pr_s = s_q[pr_line];
endmodule

// File: rtl/coh_next_state.sv
module coh_next_state
  import coh_pkg::*;
#(
  parameter int NCORE = 4,
  localparam int CW = $clog2(NCORE)
) (
  input  logic [NCORE-1:0]   cur_v,
  input  logic [NCORE-1:0]   cur_d,
  input  logic [NCORE-1:0]   cur_s,
  input  logic [CW-1:0]      req_core,
  input  coh_op_e            op,
  output logic [NCORE-1:0]   nxt_v,
  output logic [NCORE-1:0]   nxt_d,
  output logic [NCORE-1:0]   nxt_s,
  output logic [2*NCORE-1:0] cmd,
  output logic [NCORE-1:0]   mask,
  output logic               need_mem
);
  logic [NCORE-1:0] owner;
  logic [NCORE-1:0] home;
  logic             found;

  // Home core: lowest-numbered non-requester holding E, M or O.
  always_comb begin
    found = 1'b0;
    home  = '0;
    owner = '0;
    for (int i = 0; i < NCORE; i++) begin
      owner[i] = (req_core != CW'(i)) && cur_v[i] && (cur_d[i] || !cur_s[i]);
      if (owner[i] && !found) begin
        home[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  assign need_mem = ((op == OP_RDLD) || (op == OP_RDST)) && !found;

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    logic       is_req;
    logic [2:0] nst;
    snp_cmd_e   c;
    assign is_req = (req_core == CW'(i));

    always_comb begin
      nst = {cur_v[i], cur_d[i], cur_s[i]};
      c   = SN_NONE;
      if (is_req) begin
        unique case (op)
          OP_INV, OP_RDST: nst = 3'b110;
          OP_WB:           nst = 3'b000;
          default:         nst = 3'b101;
        endcase
      end else if (cur_v[i]) begin
        unique case (op)
          OP_INV, OP_WB: begin
            c   = SN_INV;
            nst = 3'b000;
          end
          OP_RDLD: begin
            if (home[i]) begin
              c   = SN_SHARE;
              nst = 3'b111;
            end
          end
          default: begin
            c   = home[i] ? SN_FLUSH : SN_INV;
            nst = 3'b000;
          end
        endcase
      end
    end

    assign nxt_v[i]       = nst[2];
    assign nxt_d[i]       = nst[1];
    assign nxt_s[i]       = nst[0];
    assign cmd[2*i +: 2]  = c;
    assign mask[i]        = (c != SN_NONE);
  end
endmodule

// File: rtl/coh_ack_tracker.sv
module coh_ack_tracker #(
  parameter int NCORE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NCORE-1:0] load_mask,
  input  logic             collect,
  input  logic [NCORE-1:0] ack,
  output logic             all_acked
);
  logic [NCORE-1:0] mask_q, mask_d;
  logic [NCORE-1:0] ack_q, ack_d;
  logic             en;

  always_comb begin
    mask_d = mask_q;
    ack_d  = ack_q;
    if (load) begin
      mask_d = load_mask;
      ack_d  = '0;
    end else if (collect) begin
      ack_d = ack_q | (ack & mask_q);
    end
  end

  assign en = load || collect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ack_q  <= '0;
    end else if (en) begin
      mask_q <= mask_d;
      ack_q  <= ack_d;
    end
  end

  assign all_acked = (ack_q == mask_q);
endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
  import coh_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int NLINE = 8,
  localparam int CW = $clog2(NCORE),
  localparam int LW = $clog2(NLINE)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [CW-1:0]      req_core,
  input  logic [1:0]         req_op,
  input  logic [LW-1:0]      req_line,
  output logic               snp_valid,
  output logic [2*NCORE-1:0] snp_cmd,
  input  logic [NCORE-1:0]   snp_ack,
  output logic               mem_req,
  output logic [LW-1:0]      mem_line,
  input  logic               mem_ack,
  output logic               rsp_valid,
  output logic [CW-1:0]      rsp_core,
  output logic               rsp_mem,
  input  logic [LW-1:0]      look_line,
  output logic [NCORE-1:0]   look_v,
  output logic [NCORE-1:0]   look_d,
  output logic [NCORE-1:0]   look_s
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  ctl_state_e st_q, st_d;
  logic       accept;

  logic [NCORE-1:0]   cur_v, cur_d, cur_s;
  logic [NCORE-1:0]   nv_c, nd_c, ns_c, mask_c;
  logic [2*NCORE-1:0] cmd_c;
  logic               mem_c;

  logic [CW-1:0]      core_q;
  logic [LW-1:0]      line_q;
  logic [NCORE-1:0]   nv_q, nd_q, ns_q;
  logic [2*NCORE-1:0] cmd_q;
  logic               mem_q;
  logic               all_acked;

  assign accept = (st_q == ST_IDLE) && req_valid;

  coh_dir_array #(.NCORE(NCORE), .NLINE(NLINE)) i_array (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .rd_line (req_line),
    .rd_v    (cur_v),
    .rd_d    (cur_d),
    .rd_s    (cur_s),
    .pr_line (look_line),
    .pr_v    (look_v),
    .pr_d    (look_d),
    .pr_s    (look_s),
    .we      (st_q == ST_REPLY),
    .wr_line (line_q),
    .wr_v    (nv_q),
    .wr_d    (nd_q),
    .wr_s    (ns_q)
  );

  coh_next_state #(.NCORE(NCORE)) i_next (
    .cur_v    (cur_v),
    .cur_d    (cur_d),
    .cur_s    (cur_s),
    .req_core (req_core),
    .op       (coh_op_e'(req_op)),
    .nxt_v    (nv_c),
    .nxt_d    (nd_c),
    .nxt_s    (ns_c),
    .cmd      (cmd_c),
    .mask     (mask_c),
    .need_mem (mem_c)
  );

  coh_ack_tracker #(.NCORE(NCORE)) i_acks (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load      (accept),
    .load_mask (mask_c),
    .collect   ((st_q == ST_ISSUE) || (st_q == ST_WAIT)),
    .ack       (snp_ack),
    .all_acked (all_acked)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_valid) st_d = ST_ISSUE;
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT:  if (all_acked) st_d = mem_q ? ST_MEM : ST_REPLY;
      ST_MEM:   if (mem_ack) st_d = ST_REPLY;
      ST_REPLY: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) st_q <= ST_IDLE;
    else            st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      core_q <= '0;
      line_q <= '0;
      nv_q   <= '0;
      nd_q   <= '0;
      ns_q   <= '0;
      cmd_q  <= '0;
      mem_q  <= 1'b0;
    end else if (accept) begin
      core_q <= req_core;
      line_q <= req_line;
      nv_q   <= nv_c;
      nd_q   <= nd_c;
      ns_q   <= ns_c;
      cmd_q  <= cmd_c;
      mem_q  <= mem_c;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign snp_valid = (st_q == ST_ISSUE) && (|cmd_q);
  assign snp_cmd   = (st_q == ST_ISSUE) ? cmd_q : '0;
  assign mem_req   = (st_q == ST_MEM);
  assign mem_line  = line_q;
  assign rsp_valid = (st_q == ST_REPLY);
  assign rsp_core  = core_q;
  assign rsp_mem   = mem_q;
endmodule

// File: rtl/coh_dir_checker.sv
module coh_dir_checker #(
  parameter int NCORE = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               snp_valid,
  input logic [2*NCORE-1:0] snp_cmd,
  input logic [NCORE-1:0]   snp_ack,
  input logic               mem_req,
  input logic               mem_ack,
  input logic               rsp_valid
);
  logic [NCORE-1:0] tgt, src, pend;

  always_comb begin
    for (int i = 0; i < NCORE; i++) begin
      tgt[i] = |snp_cmd[2*i +: 2];
      src[i] = snp_cmd[2*i+1];
    end
  end

  // Cores snooped but not yet acknowledged, seen from the ports.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pend <= '0;
    else if (snp_valid) pend <= tgt & ~snp_ack;
    else                pend <= pend & ~snp_ack;
  end

  a_r7_reply_after_acks: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (pend == '0));
  a_r7_snoop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> !snp_valid);
  a_r7_cmd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_valid |-> (snp_cmd == '0));
  a_r4_single_source: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> ($countones(src) <= 1));
  a_r8_mem_after_acks: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (pend == '0));
  a_r8_mem_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req);
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r9_ready_after_reply: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);
  a_r9_no_reply_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

bind coh_dir_ctrl coh_dir_checker #(.NCORE(NCORE)) i_coh_dir_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .snp_valid (snp_valid),
  .snp_cmd   (snp_cmd),
  .snp_ack   (snp_ack),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .rsp_valid (rsp_valid)
);

// File: tb/test_coh_dir_ctrl.sv
module test_coh_dir_ctrl;
  localparam int NCORE = 4;
  localparam int NLINE = 8;
  localparam int CW = 2;
  localparam int LW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic               req_valid, req_ready, snp_valid, mem_req, mem_ack, rsp_valid, rsp_mem;
  logic [CW-1:0]      req_core, rsp_core;
  logic [1:0]         req_op;
  logic [LW-1:0]      req_line, mem_line, look_line;
  logic [2*NCORE-1:0] snp_cmd;
  logic [NCORE-1:0]   snp_ack, look_v, look_d, look_s;

  coh_dir_ctrl #(.NCORE(NCORE), .NLINE(NLINE)) i_coh_dir_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_core(req_core), .req_op(req_op), .req_line(req_line),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_ack(snp_ack),
    .mem_req(mem_req), .mem_line(mem_line), .mem_ack(mem_ack),
    .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_mem(rsp_mem),
    .look_line(look_line), .look_v(look_v), .look_d(look_d), .look_s(look_s)
  );

  int checks = 0;
  int errors = 0;
  bit [NCORE-1:0] mv [NLINE];
  bit [NCORE-1:0] md [NLINE];
  bit [NCORE-1:0] ms [NLINE];
  logic           probe_force = 1'b0;
  logic [LW-1:0]  probe_line = '0;
  logic [LW-1:0]  sweep = '0;

  assign look_line = probe_force ? probe_line : sweep;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) sweep <= sweep + 1'b1;

  // Directory state compared against the model on every clock (R1 encoding).
  initial forever begin
    @(posedge clk);
    #2;
    if (rst_n && !probe_force)
      chk({look_v, look_d, look_s} == {mv[look_line], md[look_line], ms[look_line]},
          "R1 directory state sweep",
          int'({look_v, look_d, look_s}), int'({mv[look_line], md[look_line], ms[look_line]}));
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic predict(input int c, input int op, input int ln,
                         output bit [2*NCORE-1:0] ecmd, output bit [NCORE-1:0] emask,
                         output bit emem, output bit [NCORE-1:0] nv,
                         output bit [NCORE-1:0] nd, output bit [NCORE-1:0] ns);
    int h;
    h = -1;
    for (int i = 0; i < NCORE; i++)
      if (i != c && h < 0 && mv[ln][i] && (md[ln][i] || !ms[ln][i])) h = i;
    nv = mv[ln]; nd = md[ln]; ns = ms[ln]; ecmd = '0; emask = '0;
    emem = (op >= 2) && (h < 0);
    for (int i = 0; i < NCORE; i++) begin
      if (i == c) begin
        if (op == 1)      begin nv[i] = 0; nd[i] = 0; ns[i] = 0; end
        else if (op == 2) begin nv[i] = 1; nd[i] = 0; ns[i] = 1; end
        else              begin nv[i] = 1; nd[i] = 1; ns[i] = 0; end
      end else if (mv[ln][i]) begin
        if (op == 2) begin
          if (i == h) begin ecmd[2*i +: 2] = 2'd2; nd[i] = 1; ns[i] = 1; end
        end else begin
          ecmd[2*i +: 2] = (op == 3 && i == h) ? 2'd3 : 2'd1;
          nv[i] = 0; nd[i] = 0; ns[i] = 0;
        end
      end
      emask[i] = (ecmd[2*i +: 2] != 2'd0);
    end
  endtask

  task automatic do_req(input int c, input int op, input int ln, input int ackdly,
                        input int memdly, input bit rogue, input string tag);
    bit [2*NCORE-1:0] ecmd;
    bit [NCORE-1:0]   emask, nv, nd, ns;
    bit               emem, memseen, done;
    int               acks_left, t, memcnt;
    predict(c, op, ln, ecmd, emask, emem, nv, nd, ns);
    acks_left = $countones(emask);
    @(negedge clk);
    chk(req_ready == 1'b1, {tag, " R9 ready before request"}, int'(req_ready), 1);
    req_valid = 1'b1; req_core = CW'(c); req_op = 2'(op); req_line = LW'(ln);
    @(negedge clk);
    req_valid = 1'b0;
    chk(snp_valid == (emask != 0), {tag, " R7 snoop valid"}, int'(snp_valid), int'(emask != 0));
    chk(snp_cmd == ecmd, {tag, " snoop commands"}, int'(snp_cmd), int'(ecmd));
    t = 0; memcnt = 0; memseen = 0; done = 0;
    while (!done && t < 200) begin
      if (rsp_valid) begin
        chk(acks_left == 0, {tag, " R7 reply after all acks"}, acks_left, 0);
        chk(memseen == emem, {tag, " R6 memory fetch used"}, int'(memseen), int'(emem));
        chk(rsp_core == CW'(c), {tag, " reply core"}, int'(rsp_core), c);
        chk(rsp_mem == emem, {tag, " R6 reply source"}, int'(rsp_mem), int'(emem));
        mv[ln] = nv; md[ln] = nd; ms[ln] = ns;
        done = 1;
      end else begin
        chk(req_ready == 1'b0, {tag, " R9 busy"}, int'(req_ready), 0);
        if (mem_req && !memseen) begin
          chk(acks_left == 0, {tag, " R8 memory after acks"}, acks_left, 0);
          chk(emem, {tag, " R6 memory fetch expected"}, 1, int'(emem));
          chk(mem_line == LW'(ln), {tag, " R6 memory line"}, int'(mem_line), ln);
        end
        if (!mem_req && memseen)
          chk(0, {tag, " R8 memory request held"}, 0, 1);
        if (mem_req) memseen = 1;
      end
      snp_ack = '0;
      mem_ack = 1'b0;
      req_valid = 1'b0;
      if (!done) begin
        for (int i = 0; i < NCORE; i++)
          if (emask[i] && t == ackdly + 2*i) begin snp_ack[i] = 1'b1; acks_left--; end
        if (t == 0) snp_ack = snp_ack | ~emask;
        if (mem_req) begin
          if (memcnt == memdly) mem_ack = 1'b1;
          memcnt++;
        end
        if (rogue && t == 1) begin
          req_valid = 1'b1; req_core = CW'((c + 1) % NCORE); req_op = 2'd3; req_line = 3'd7;
        end
        @(negedge clk);
        t++;
      end
    end
    if (!done) chk(0, {tag, " R7 reply never arrived"}, 0, 1);
    @(negedge clk);
    chk(req_ready == 1'b1, {tag, " R9 ready after reply"}, int'(req_ready), 1);
    probe_force = 1'b1; probe_line = LW'(ln);
    #1;
    chk({look_v, look_d, look_s} == {nv, nd, ns}, {tag, " final line state"},
        int'({look_v, look_d, look_s}), int'({nv, nd, ns}));
    if (rogue) begin
      probe_line = 3'd7;
      #1;
      chk({look_v, look_d, look_s} == '0, {tag, " R9 busy request ignored"},
          int'({look_v, look_d, look_s}), 0);
    end
    probe_force = 1'b0;
  endtask

  initial begin
    req_valid = 0; req_core = '0; req_op = '0; req_line = '0; snp_ack = '0; mem_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    chk(!snp_valid && !mem_req && !rsp_valid, "R1 reset outputs quiet",
        int'({snp_valid, mem_req, rsp_valid}), 0);
    probe_force = 1'b1;
    for (int l = 0; l < NLINE; l++) begin
      probe_line = LW'(l);
      #1;
      chk({look_v, look_d, look_s} == '0, "R1 reset line invalid", int'({look_v, look_d, look_s}), 0);
    end
    probe_force = 1'b0;

    do_req(0, 2, 1, 1, 0, 0, "R6 load miss");
    do_req(1, 2, 1, 0, 2, 0, "R6 load with only sharers");
    do_req(2, 3, 1, 1, 3, 1, "R5 store miss invalidating sharers");
    do_req(3, 2, 1, 2, 0, 0, "R4 load from modified home");
    do_req(0, 2, 1, 0, 0, 0, "R4 load from owned home");
    do_req(1, 3, 1, 3, 0, 0, "R5 store with owned home");
    do_req(1, 1, 1, 0, 0, 0, "R3 writeback alone");
    do_req(0, 2, 2, 0, 1, 0, "R6 second line load");
    do_req(1, 2, 2, 1, 0, 0, "R6 second line shared load");
    do_req(3, 0, 2, 2, 0, 1, "R2 invalidate sharers");
    do_req(0, 2, 2, 0, 0, 0, "R4 load from modified second line");
    do_req(3, 1, 2, 1, 0, 0, "R3 writeback with sharer");
    do_req(2, 0, 3, 0, 0, 0, "R2 invalidate without other copies");

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule